// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Mid-Stop Rearm

This block recovers 8N1 asynchronous serial bytes from a single input line. It runs on the system clock and advances only on a one-cycle enable that pulses at sixteen times the bit rate. The line passes through a synchroniser. A high-to-low transition seen between two ticks starts a frame. The start bit is confirmed near its centre, and then each data bit and the stop bit is sampled once per bit period at a parameterised phase.

The receiver finishes a frame at the stop-bit sample, not at the end of the stop bit. At that tick it hands the byte to a one-byte holding register, pulses a strobe, flags a low stop bit as a framing error and goes straight back to hunting for a start edge. A sender whose clock runs a little fast can therefore start its next frame during the second half of the local stop bit without losing that frame. Software-side logic reads the held byte with a one-cycle read pulse. A byte that completes before the previous one was read replaces it and raises an overrun flag.

Top module: `serial_rx_rearm`

## Requirements
- R1: After reset, data_o is 0 and valid_o, strobe_o, ferr_o and overrun_o are all 0.
- R2: Data bits are taken least significant bit first, so the byte on data_o equals the eight data-bit values in line order, with the first data bit in bit 0.
- R3: Number the ticks from 1, where tick 1 is the first tick that sees the line low after it was high. The stop bit is sampled on tick 1+SAMPLE_PHASE+16*9, which is tick 152 with the default SAMPLE_PHASE of 7. strobe_o is high for exactly the one clock cycle after that tick, and data_o, ferr_o and valid_o take their new values in that same cycle.
- R4: Start-edge search resumes on the tick after the stop sample. A new frame whose start bit begins on tick 153 of the previous frame is received correctly.
- R5: If the line is high again at the start-bit check (tick 1+SAMPLE_PHASE), the receiver returns to idle with no strobe and the holding register is unchanged.
- R6: ferr_o is high together with strobe_o exactly when the stop sample is low. The byte is still delivered, and no spurious frame follows while the line stays low and then rises.
- R7: valid_o is set when a byte completes. A rd_i pulse with no completion in the same cycle clears valid_o and overrun_o on the next cycle. data_o changes only when strobe_o is high.
- R8: If a byte completes while valid_o is high and rd_i is low, overrun_o is set and data_o takes the newer byte.
- R9: strobe_o never stays high for two consecutive cycles, and ferr_o is never high without strobe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Enable pulse at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| rd_i | input | 1 | Read pulse that consumes the held byte |
| data_o | output | 8 | Held received byte |
| valid_o | output | 1 | Held byte not yet read |
| strobe_o | output | 1 | One-cycle pulse when a byte completes |
| ferr_o | output | 1 | Framing error, coincident with strobe_o |
| overrun_o | output | 1 | Unread byte was overwritten; cleared by rd_i |

## Verification
A line change needs two clock edges to cross the synchroniser. The frame logic then acts on it at the next tick, and every result from a stop sample is visible in the cycle right after that tick. The bench therefore advances in three-cycle tick slots. It changes rxd_i at the start of each slot and raises tick_i in the slot's last cycle. It samples all outputs at the falling edge that opens the next slot, and records for each strobe the slot number of the tick that caused it, comparing that slot number with tick 152 of the frame. A read pulse is applied in the first cycle of a slot, so its effect on valid_o and overrun_o is visible before the next tick.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OVS          = 16,
  parameter int SAMPLE_PHASE = 7,   // 1..OVS-1, ticks after edge detection tick
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 stop_ok_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] CNT_LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_PHASE = CW'(SAMPLE_PHASE);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [CW-1:0]        cnt_q;
  logic [BW-1:0]        bit_q;
  logic                 prev_q;
  logic [DATA_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      prev_q  <= 1'b1;
      sh_q    <= '0;
    end else if (tick_i) begin
      prev_q <= line_i;
      unique case (state_q)
        RX_IDLE: begin
          if (prev_q && !line_i) begin
            state_q <= RX_START;
            cnt_q   <= CW'(1);
          end
        end
        RX_START: begin
          if (cnt_q == CNT_PHASE) begin
            cnt_q <= '0;
            bit_q <= '0;
            state_q <= line_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            sh_q  <= {line_i, sh_q[DATA_BITS-1:1]};
            if (bit_q == BIT_LAST) state_q <= RX_STOP;
            else                   bit_q   <= bit_q + BW'(1);
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        RX_STOP: begin
          // rearm at the stop-bit centre, not its end
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o    = tick_i && (state_q == RX_STOP) && (cnt_q == CNT_LAST);
  assign byte_o    = sh_q;
  assign stop_ok_o = line_i;

  p_rearm_after_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == RX_IDLE));

  p_false_start_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == RX_START && state_q == RX_IDLE) |-> ($past(line_i) && $past(tick_i)));
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] byte_i,
  input  logic          stop_ok_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          strobe_o,
  output logic          ferr_o,
  output logic          overrun_o
);
  logic [DW-1:0] data_q;
  logic          valid_q, strobe_q, ferr_q, overrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      valid_q   <= 1'b0;
      strobe_q  <= 1'b0;
      ferr_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      strobe_q <= done_i;
      ferr_q   <= done_i && !stop_ok_i;
      if (done_i) begin
        // completion wins over a same-cycle read
        data_q  <= byte_i;
        valid_q <= 1'b1;
        if (valid_q && !rd_i) overrun_q <= 1'b1;
        else if (rd_i)        overrun_q <= 1'b0;
      end else if (rd_i) begin
        valid_q   <= 1'b0;
        overrun_q <= 1'b0;
      end
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign strobe_o  = strobe_q;
  assign ferr_o    = ferr_q;
  assign overrun_o = overrun_q;

  p_strobe_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);

  p_ferr_with_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_q |-> strobe_q);

  p_valid_on_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> valid_q);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!valid_q && !overrun_q));

  p_data_only_on_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_q |-> $stable(data_q));

  p_overrun_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && valid_q && !rd_i) |=> overrun_q);
endmodule

// File: rtl/serial_rx_rearm.sv
module serial_rx_rearm #(
  parameter int OVS          = 16,
  parameter int SAMPLE_PHASE = 7,
  parameter int DATA_BITS    = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 strobe_o,
  output logic                 ferr_o,
  output logic                 overrun_o
);
  logic                 line_s;
  logic                 done;
  logic                 stop_ok;
  logic [DATA_BITS-1:0] byte_w;

  serial_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  serial_rx_frame #(
    .OVS         (OVS),
    .SAMPLE_PHASE(SAMPLE_PHASE),
    .DATA_BITS   (DATA_BITS)
  ) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .line_i   (line_s),
    .done_o   (done),
    .byte_o   (byte_w),
    .stop_ok_o(stop_ok)
  );

  serial_rx_hold #(.DW(DATA_BITS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .byte_i   (byte_w),
    .stop_ok_i(stop_ok),
    .rd_i     (rd_i),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .strobe_o (strobe_o),
    .ferr_o   (ferr_o),
    .overrun_o(overrun_o)
  );
endmodule

// File: tb/serial_rx_rearm_tb_top.sv
`timescale 1ns/1ps
module serial_rx_rearm_tb_top;
  localparam int PHASE    = 7;
  localparam int STOP_REL = 1 + PHASE + 16 * 9; // tick of stop sample
  localparam int MAXC     = 512;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       rd_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, strobe_o, ferr_o, overrun_o;

  always #2 clk_i = ~clk_i;

  serial_rx_rearm #(.SAMPLE_PHASE(PHASE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i), .rd_i(rd_i),
    .data_o(data_o), .valid_o(valid_o), .strobe_o(strobe_o),
    .ferr_o(ferr_o), .overrun_o(overrun_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int gslot = 0;
  int n_st  = 0;
  bit auto_rd = 1'b0;
  int         cap_slot [MAXC];
  logic [7:0] cap_data [MAXC];
  logic       cap_ferr [MAXC];
  logic       cap_ovr  [MAXC];
  logic       cap_val  [MAXC];
  int         f0       [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one tick slot: observe, drive line/rd, then tick in the third cycle
  task automatic slot(input logic line, input logic rd_now);
    logic do_rd;
    @(negedge clk_i);
    do_rd = rd_now;
    if (strobe_o) begin
      if (n_st < MAXC) begin
        cap_slot[n_st] = gslot;
        cap_data[n_st] = data_o;
        cap_ferr[n_st] = ferr_o;
        cap_ovr[n_st]  = overrun_o;
        cap_val[n_st]  = valid_o;
      end
      n_st++;
      if (auto_rd) do_rd = 1'b1;
    end
    gslot++;
    rxd_i  = line;
    tick_i = 1'b0;
    rd_i   = do_rd;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
    tick_i = 1'b1;
  endtask

  task automatic frame(input logic [7:0] b, input int stop_len, input logic stop_v);
    for (int i = 0; i < 16; i++) slot(1'b0, 1'b0);
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 16; i++) slot(b[k], 1'b0);
    for (int i = 0; i < stop_len; i++) slot(stop_v, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1, 1'b0);
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(data_o == 8'h00, "R1 data", data_o, 0);
    chk(!valid_o && !strobe_o, "R1 valid/strobe", {valid_o, strobe_o}, 0);
    chk(!ferr_o && !overrun_o, "R1 ferr/overrun", {ferr_o, overrun_o}, 0);
    idle(4);

    // R2 R3 R4: all bytes, odd ones followed by earliest allowed start (tick 153)
    auto_rd = 1'b1;
    base = n_st;
    for (int b = 0; b < 256; b++) begin
      f0[b] = gslot + 1;
      frame(8'(b), (b % 2 == 1) ? 8 : 16, 1'b1);
    end
    idle(20);
    chk(n_st - base == 256, "R4 frame count", n_st - base, 256);
    for (int b = 0; b < 256; b++) begin
      chk(cap_data[base + b] == 8'(b), "R2 data lsb first", cap_data[base + b], b);
      chk(cap_slot[base + b] == f0[b] + STOP_REL - 1, "R3 strobe tick",
          cap_slot[base + b] - f0[b] + 1, STOP_REL);
      chk(!cap_ferr[base + b] && !cap_ovr[base + b] && cap_val[base + b],
          "R7 flags at strobe", {cap_ferr[base + b], cap_ovr[base + b], cap_val[base + b]}, 1);
    end
    chk(!valid_o, "R7 read clears valid", valid_o, 0);

    // R6 framing error, low stop held then released
    base = n_st;
    frame(8'hA5, 30, 1'b0);
    idle(60);
    chk(n_st - base == 1, "R6 single strobe", n_st - base, 1);
    chk(cap_ferr[base] == 1'b1, "R6 ferr with strobe", cap_ferr[base], 1);
    chk(cap_data[base] == 8'hA5, "R6 byte delivered", cap_data[base], 8'hA5);
    chk(!ferr_o, "R9 ferr not held", ferr_o, 0);

    // R5 false start: low for 4 ticks only
    base = n_st;
    for (int i = 0; i < 4; i++) slot(1'b0, 1'b0);
    idle(200);
    chk(n_st == base, "R5 no strobe", n_st - base, 0);
    chk(!valid_o && data_o == 8'hA5, "R5 holding unchanged", {valid_o, data_o}, 8'hA5);

    // R8 overrun without reads
    auto_rd = 1'b0;
    base = n_st;
    frame(8'h3C, 16, 1'b1);
    frame(8'hC3, 16, 1'b1);
    idle(10);
    chk(n_st - base == 2, "R8 two strobes", n_st - base, 2);
    chk(cap_ovr[base] == 1'b0, "R8 first no overrun", cap_ovr[base], 0);
    chk(cap_ovr[base + 1] == 1'b1, "R8 overrun set", cap_ovr[base + 1], 1);
    chk(cap_data[base + 1] == 8'hC3, "R8 newer byte kept", cap_data[base + 1], 8'hC3);
    chk(overrun_o && valid_o, "R8 overrun sticky", {overrun_o, valid_o}, 3);
    slot(1'b1, 1'b1);
    slot(1'b1, 1'b0);
    chk(!valid_o && !overrun_o, "R7 read clears flags", {valid_o, overrun_o}, 0);
    chk(!strobe_o, "R9 strobe idle", strobe_o, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule